// File: doc/BRIEF.md
# Power-Management Configuration Register with Periodic SMI Timer

This block is a 16-bit power-management configuration register together with the small amount of logic it steers. Software writes the register through a plain write strobe and data bus and reads it back on a combinational read bus.

Two bits of the register pick the period of a system-management interrupt timer. The timer counts a slow (nominally 1 Hz) timebase strobe and emits a one-clock pulse at the end of each period. The pulse is emitted only while a separate global SMI enable is set.

A sticky lock bit freezes that global enable. Once set, the lock can be cleared only by the platform reset. Another bit lets the CPU sleep output assert in the lightest sleep state, while the deep sleep states assert it regardless of that bit. A read-only bit shows the power-button pin level after a two-flop synchronizer. All unused bits read as zero.

Top module: `pm_cfg_timer`

## Requirements
- R1: After the synchronous active-high reset, `rd_data` reads 16'h0000 (with the button pin low), and `smi_pulse`, `cpu_slp` and `gsmi_en` are 0.
- R2: Bits [1:0] select the timer period in ticks. The period is BASE_TICKS*8 for 00, BASE_TICKS*4 for 01, BASE_TICKS*2 for 10 and BASE_TICKS for 11, which gives 64/32/16/8 s at the default BASE_TICKS=8 and a 1 Hz tick. `smi_pulse` is high for exactly one clock, in the cycle after the clock edge that samples the tick completing the period.
- R3: Every register write restarts the tick count from zero, so the newly written period applies in full from that write.
- R4: Bit 4 (lock) is set by writing 1 and stays 1 through later writes of 0 until reset.
- R5: While the lock bit reads 1, strobes on `gsmi_wr` leave `gsmi_en` unchanged.
- R6: With bit 5 at 0, `cpu_slp` stays 0 while `sleep_state` is 3'd1 (S1). With bit 5 at 1, `cpu_slp` is 1 one cycle after S1 is presented.
- R7: `cpu_slp` is 1 one cycle after `sleep_state` is 3'd3, 3'd4 or 3'd5 (S3/S4/S5), whatever bit 5 holds. The codes 0, 2, 6 and 7 are awake states that give 0.
- R8: Bits 15:10, 8:6 and 3:2 always read 0, and writes to them have no effect.
- R9: `smi_pulse` is never asserted while `gsmi_en` is 0. The tick count still advances while `gsmi_en` is 0.
- R10: Bit 9 shows `pwrbtn_pin`. A pin change becomes visible in `rd_data` after the second rising clock edge that samples it, and not after the first.
- R11: While unlocked, a `gsmi_wr` strobe loads `gsmi_wdata` into `gsmi_en`, which is visible after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high platform reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register read value |
| gsmi_wr | input | 1 | Write strobe for the global SMI enable |
| gsmi_wdata | input | 1 | New value for the global SMI enable |
| gsmi_en | output | 1 | Effective global SMI enable |
| sleep_state | input | 3 | Current sleep state: 0=S0, 1=S1, 3=S3, 4=S4, 5=S5 |
| pwrbtn_pin | input | 1 | Asynchronous power-button pin |
| tick | input | 1 | One-clock timebase strobe |
| smi_pulse | output | 1 | One-clock periodic SMI pulse |
| cpu_slp | output | 1 | CPU sleep output, active high |

## Verification
Register fields, the lock and `gsmi_en` are due one edge after their write strobe. `cpu_slp` is due one edge after `sleep_state` changes. `smi_pulse` is due one edge after the tick that completes the period. Bit 9 is due two edges after a pin change.

The bench drives every input on the falling clock edge and samples on the next falling edge. Each result is therefore read half a cycle after the edge on which it is due. For bit 9, the bench also reads after the first edge to confirm the value has not yet changed.

Timer periods are swept over all four codes at BASE_TICKS=2. The expected tick counts are computed as 2<<(3-code). Sleep handling is swept over every state code with both values of bit 5.

// File: rtl/pm_cfg_pkg.sv
package pm_cfg_pkg;
  localparam int REG_W     = 16;
  localparam int RATE_LSB  = 0;
  localparam int LOCK_BIT  = 4;
  localparam int SLPEN_BIT = 5;
  localparam int BTN_BIT   = 9;

  typedef enum logic [2:0] {
    ST_S0 = 3'd0,
    ST_S1 = 3'd1,
    ST_S3 = 3'd3,
    ST_S4 = 3'd4,
    ST_S5 = 3'd5
  } sleep_t;

  localparam logic [REG_W-1:0] RSV_MASK = 16'hFDCC;
endpackage

// File: rtl/pm_sync2.sv
module pm_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/pm_cfg_regs.sv
module pm_cfg_regs
  import pm_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             gsmi_wr,
  input  logic             gsmi_wdata,
  input  logic             btn_sync,
  output logic [1:0]       rate_sel,
  output logic             slp_en,
  output logic             lock,
  output logic             gsmi_en,
  output logic             restart,
  output logic [REG_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rate_sel <= 2'b00;
      slp_en   <= 1'b0;
      lock     <= 1'b0;
    end else if (wr_en) begin
      rate_sel <= wr_data[RATE_LSB +: 2];
      slp_en   <= wr_data[SLPEN_BIT];
      lock     <= lock | wr_data[LOCK_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                   gsmi_en <= 1'b0;
    else if (gsmi_wr && !lock) gsmi_en <= gsmi_wdata;
  end

  assign restart = wr_en;

  always_comb begin
    rd_data                   = '0;
    rd_data[RATE_LSB +: 2]    = rate_sel;
    rd_data[LOCK_BIT]         = lock;
    rd_data[SLPEN_BIT]        = slp_en;
    rd_data[BTN_BIT]          = btn_sync;
  end
endmodule

// File: rtl/pm_periodic_timer.sv
module pm_periodic_timer #(
  parameter int BASE_TICKS = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       restart,
  input  logic [1:0] rate_sel,
  input  logic       enable,
  output logic       pulse
);
  localparam int MAX_TICKS = BASE_TICKS * 8;
  localparam int CW        = $clog2(MAX_TICKS + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  always_comb begin
    case (rate_sel)
      2'b00:   last = CW'(BASE_TICKS * 8 - 1);
      2'b01:   last = CW'(BASE_TICKS * 4 - 1);
      2'b10:   last = CW'(BASE_TICKS * 2 - 1);
      default: last = CW'(BASE_TICKS - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else if (restart) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else if (tick) begin
      if (cnt >= last) begin
        cnt   <= '0;
        pulse <= enable;
      end else begin
        cnt   <= cnt + 1'b1;
        pulse <= 1'b0;
      end
    end else begin
      pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/pm_cpu_sleep.sv
module pm_cpu_sleep
  import pm_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] sleep_state,
  input  logic       slp_en,
  output logic       cpu_slp
);
  logic want;

  always_comb begin
    case (sleep_state)
      ST_S1:               want = slp_en;
      ST_S3, ST_S4, ST_S5: want = 1'b1;
      default:             want = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cpu_slp <= 1'b0;
    else     cpu_slp <= want;
  end
endmodule

// File: rtl/pm_cfg_timer.sv
module pm_cfg_timer
  import pm_cfg_pkg::*;
#(
  parameter int BASE_TICKS  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             gsmi_wr,
  input  logic             gsmi_wdata,
  output logic             gsmi_en,
  input  logic [2:0]       sleep_state,
  input  logic             pwrbtn_pin,
  input  logic             tick,
  output logic             smi_pulse,
  output logic             cpu_slp
);
  logic       btn_sync;
  logic [1:0] rate_sel;
  logic       slp_en;
  logic       lock;
  logic       restart;

  pm_sync2 #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pwrbtn_pin), .dout(btn_sync)
  );

  pm_cfg_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .gsmi_wr(gsmi_wr), .gsmi_wdata(gsmi_wdata), .btn_sync(btn_sync),
    .rate_sel(rate_sel), .slp_en(slp_en), .lock(lock),
    .gsmi_en(gsmi_en), .restart(restart), .rd_data(rd_data)
  );

  pm_periodic_timer #(.BASE_TICKS(BASE_TICKS)) u_timer (
    .clk(clk), .rst(rst), .tick(tick), .restart(restart),
    .rate_sel(rate_sel), .enable(gsmi_en), .pulse(smi_pulse)
  );

  pm_cpu_sleep u_slp (
    .clk(clk), .rst(rst), .sleep_state(sleep_state),
    .slp_en(slp_en), .cpu_slp(cpu_slp)
  );
endmodule

// File: rtl/pm_cfg_timer_chk.sv
module pm_cfg_timer_chk
  import pm_cfg_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             gsmi_wr,
  input logic [2:0]       sleep_state,
  input logic [REG_W-1:0] rd_data,
  input logic             gsmi_en,
  input logic             smi_pulse,
  input logic             cpu_slp
);
  a_r4_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    rd_data[LOCK_BIT] |=> rd_data[LOCK_BIT]);

  a_r5_gsmi_frozen: assert property (@(posedge clk) disable iff (rst)
    (rd_data[LOCK_BIT] && gsmi_wr) |=> $stable(gsmi_en));

  a_r6_s1_gated: assert property (@(posedge clk) disable iff (rst)
    (sleep_state == 3'd1 && !rd_data[SLPEN_BIT]) |=> !cpu_slp);

  a_r7_deep_sleep: assert property (@(posedge clk) disable iff (rst)
    (sleep_state inside {3'd3, 3'd4, 3'd5}) |=> cpu_slp);

  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_data & RSV_MASK) == '0);

  a_r9_pulse_needs_en: assert property (@(posedge clk) disable iff (rst)
    smi_pulse |-> $past(gsmi_en));

  a_r3_no_pulse_after_write: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !smi_pulse);
endmodule

bind pm_cfg_timer pm_cfg_timer_chk i_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .gsmi_wr(gsmi_wr),
  .sleep_state(sleep_state), .rd_data(rd_data), .gsmi_en(gsmi_en),
  .smi_pulse(smi_pulse), .cpu_slp(cpu_slp)
);

// File: tb/test_pm_cfg_timer.sv
module test_pm_cfg_timer;
  localparam int CLK_PERIOD = 10;
  localparam int BASE       = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        gsmi_wr = 1'b0;
  logic        gsmi_wdata = 1'b0;
  logic        gsmi_en;
  logic [2:0]  sleep_state = 3'd0;
  logic        pwrbtn_pin = 1'b0;
  logic        tick = 1'b0;
  logic        smi_pulse;
  logic        cpu_slp;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pm_cfg_timer #(.BASE_TICKS(BASE)) i_pm_cfg_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .gsmi_wr(gsmi_wr), .gsmi_wdata(gsmi_wdata), .gsmi_en(gsmi_en),
    .sleep_state(sleep_state), .pwrbtn_pin(pwrbtn_pin), .tick(tick),
    .smi_pulse(smi_pulse), .cpu_slp(cpu_slp)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; cyc(); cyc(); rst = 1'b0;
  endtask

  task automatic reg_wr(input logic [15:0] d);
    wr_en = 1'b1; wr_data = d; cyc(); wr_en = 1'b0;
  endtask

  task automatic gsmi_set(input logic v);
    gsmi_wr = 1'b1; gsmi_wdata = v; cyc(); gsmi_wr = 1'b0;
  endtask

  task automatic do_tick(output logic p);
    tick = 1'b1; cyc(); tick = 1'b0; p = smi_pulse;
  endtask

  task automatic measure(input int sel, input string req);
    logic p;
    int   k;
    int   exp_n;
    exp_n = BASE << (3 - sel);
    for (int rep = 0; rep < 2; rep++) begin
      k = 0; p = 1'b0;
      while (!p && k < 100) begin
        do_tick(p); k++;
        cyc();
        if (p) check({req, " pulse width"}, {15'd0, smi_pulse}, 16'd0);
      end
      check(req, 16'(k), 16'(exp_n));
    end
  endtask

  initial begin
    logic p;
    do_reset();
    // R1 reset state
    check("R1 rd_data", rd_data, 16'h0000);
    check("R1 outputs", {13'd0, smi_pulse, cpu_slp, gsmi_en}, 16'd0);

    // R11 global enable writable while unlocked
    gsmi_set(1'b1);
    check("R11 gsmi_en set", {15'd0, gsmi_en}, 16'd1);

    // R2 all four rate codes
    for (int s = 0; s < 4; s++) begin
      reg_wr(16'(s));
      check("R2 rate readback", rd_data, 16'(s));
      measure(s, "R2 period ticks");
    end

    // R3 write restarts count: code 11 = 2 ticks
    reg_wr(16'h0003);
    do_tick(p); cyc();
    reg_wr(16'h0003);
    do_tick(p);
    check("R3 no pulse after restart", {15'd0, p}, 16'd0);
    cyc();
    do_tick(p);
    check("R3 pulse after full period", {15'd0, p}, 16'd1);

    // R9 gated pulse, count keeps running
    gsmi_set(1'b0);
    reg_wr(16'h0003);
    do_tick(p); cyc();
    check("R9 disabled tick1", {15'd0, p}, 16'd0);
    do_tick(p); cyc();
    check("R9 disabled period end", {15'd0, p}, 16'd0);
    gsmi_set(1'b1);
    do_tick(p); cyc();
    check("R9 count advanced while off", {15'd0, p}, 16'd0);
    do_tick(p);
    check("R9 pulse when re-enabled", {15'd0, p}, 16'd1);

    // R6/R7 exhaustive sleep sweep
    for (int en = 0; en < 2; en++) begin
      reg_wr(16'(en << 5));
      for (int st = 0; st < 8; st++) begin
        logic e;
        sleep_state = 3'(st);
        cyc();
        e = (st == 3 || st == 4 || st == 5) ? 1'b1 : (st == 1) ? 1'(en) : 1'b0;
        check((st == 1) ? "R6 S1 gating" : "R7 sleep state", {15'd0, cpu_slp}, {15'd0, e});
      end
    end
    sleep_state = 3'd0;

    // R10 synchronizer latency
    pwrbtn_pin = 1'b1; cyc();
    check("R10 after one edge", {15'd0, rd_data[9]}, 16'd0);
    cyc();
    check("R10 after two edges", {15'd0, rd_data[9]}, 16'd1);
    pwrbtn_pin = 1'b0; cyc(); cyc();
    check("R10 falls", {15'd0, rd_data[9]}, 16'd0);

    // R8 reserved bits
    reg_wr(16'hFDCC);
    check("R8 reserved ignored", rd_data, 16'h0000);

    // R4 / R5 lock
    gsmi_set(1'b1);
    reg_wr(16'h0010);
    check("R4 lock set", rd_data, 16'h0010);
    gsmi_set(1'b0);
    check("R5 gsmi frozen", {15'd0, gsmi_en}, 16'd1);
    reg_wr(16'h0001);
    check("R4 lock sticky", rd_data, 16'h0011);
    reg_wr(16'hFFFF);
    check("R8 full write", rd_data, 16'h0033);
    do_reset();
    check("R4 reset clears lock", rd_data, 16'h0000);
    gsmi_set(1'b1);
    check("R11 writable after reset", {15'd0, gsmi_en}, 16'd1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule